// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial bus in front of a small byte array. It watches the clock and data lines through synchronizers running on the system clock. It recognizes start and stop conditions and compares the first byte of each transfer against a fixed device identifier and select code. When that byte matches, the block either writes one byte or reads bytes out one after another. The data line is open-drain: the block has an output enable that pulls the line low when set and leaves it released when clear.

A byte write is not committed when its last bit arrives. The commit happens at the stop condition that closes the transfer, and it then starts a timed internal write cycle. For that whole cycle a busy flag is high and the block ignores the bus completely. Addresses inside a configurable protected window refuse data: the data byte is not acknowledged and nothing is stored.

Top module: `twowire_mem_slave`

## Requirements
- R1: During and right after reset, `sda_oe` and `busy` are both 0.
- R2: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. A stop that ends a transfer with no accepted data byte returns the block to idle and stores nothing.
- R3: The first byte after a start is received MSB first. The block acknowledges it, by driving SDA low on the ninth clock, only when bits 7..4 equal `DEV_ID` and bits 3..1 equal `DEV_SEL`. Bit 0 selects read (1) or write (0).
- R4: When the address byte does not match, the block gives no acknowledge and acknowledges no later byte until the next start.
- R5: In write mode the block acknowledges the word address byte and each data byte that goes to an unprotected address.
- R6: After start, address byte, word address, data byte and stop, the data byte is stored at the word address, and a later read returns it.
- R7: The stop that commits a write raises `busy` for exactly `WR_CYCLES` clocks. While `busy` is high the block acknowledges nothing and keeps `sda_oe` at 0.
- R8: A data byte whose word address lies in `[PROT_LO, PROT_HI]` gets no acknowledge. The array keeps its old value and `busy` does not rise.
- R9: In read mode the block sends bytes MSB first from the current address. After each byte that the master acknowledges, the address advances by one and wraps from the last location to 0.
- R10: When the master does not acknowledge a read byte, the block releases SDA and stays silent until the next start or stop.
- R11: `sda_oe` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| busy | output | 1 | High during the internal write cycle |

## Verification
Writes go to an unprotected address, to the top of the protected window, and to a transfer cut off by a stop right after the word address. Telling these apart shows that only an acknowledged data byte followed by a stop commits and starts the busy window. Address bytes with a wrong select code and with a wrong identifier are tried separately, and both must be refused along with the bytes that follow them. A sequential read that begins two locations before the end of the array and ends in a master NACK checks the wrap and the silence after the NACK. An address byte sent during the busy window checks that the bus is ignored.

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave #(
  parameter logic [3:0] DEV_ID    = 4'hA,
  parameter logic [2:0] DEV_SEL   = 3'd1,
  parameter int         ADDR_W    = 4,
  parameter int         PROT_LO   = 12,
  parameter int         PROT_HI   = 15,
  parameter int         WR_CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  output logic busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int TW = $clog2(WR_CYCLES + 1);
  localparam logic [ADDR_W-1:0] P_LO = ADDR_W'(PROT_LO);
  localparam logic [ADDR_W-1:0] P_HI = ADDR_W'(PROT_HI);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WADR, S_WDAT, S_READ, S_WAIT} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic scl_q, sda_q;
  st_t st;
  logic [3:0] cnt;
  logic [7:0] sh, wdat;
  logic [ADDR_W-1:0] addr;
  logic pend, okay, mack;
  logic [TW-1:0] tmr;
  logic [7:0] mem [DEPTH];

  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire [ADDR_W-1:0] nxt = addr + 1'b1;
  wire [7:0] cur = mem[addr];
  wire prot = (addr >= P_LO) && (addr <= P_HI);
  wire id_ok = (sh[7:1] == {DEV_ID, DEV_SEL});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
      st <= S_IDLE; cnt <= '0; sh <= '0; wdat <= '0; addr <= '0;
      pend <= 1'b0; okay <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0;
      busy <= 1'b0; tmr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
      if (busy) begin
        if (tmr == '0) busy <= 1'b0;
        else tmr <= tmr - 1'b1;
      end else if (start_det) begin
        st <= S_DEV; cnt <= '0; sda_oe <= 1'b0; pend <= 1'b0;
      end else if (stop_det) begin
        st <= S_IDLE; cnt <= '0; sda_oe <= 1'b0; pend <= 1'b0;
        if (pend) begin
          mem[addr] <= wdat;
          busy <= 1'b1;
          tmr <= TW'(WR_CYCLES - 1);
        end
      end else if (st != S_IDLE && st != S_WAIT) begin
        if (scl_rise) begin
          if (cnt < 4'd8) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (cnt == 4'd8) begin
            mack <= ~sda_s;
            cnt  <= 4'd9;
          end
        end else if (scl_fall) begin
          if (cnt == 4'd8) begin
            case (st)
              S_DEV:   begin okay <= id_ok; sda_oe <= id_ok; end
              S_WADR:  begin okay <= 1'b1;  sda_oe <= 1'b1;  end
              S_WDAT:  begin okay <= ~prot; sda_oe <= ~prot; end
              default: sda_oe <= 1'b0;
            endcase
          end else if (cnt == 4'd9) begin
            cnt <= '0;
            sda_oe <= 1'b0;
            case (st)
              S_DEV:
                if (!okay) st <= S_WAIT;
                else if (sh[0]) begin st <= S_READ; sda_oe <= ~cur[7]; end
                else st <= S_WADR;
              S_WADR: begin addr <= sh[ADDR_W-1:0]; st <= S_WDAT; end
              S_WDAT:
                if (okay) begin wdat <= sh; pend <= 1'b1; end
                else st <= S_WAIT;
              S_READ:
                if (mack) begin addr <= nxt; sda_oe <= ~mem[nxt][7]; end
                else st <= S_WAIT;
              default: st <= S_WAIT;
            endcase
          end else if (st == S_READ && cnt != '0) begin
            sda_oe <= ~cur[3'd7 - cnt[2:0]];
          end
        end
      end
    end
  end

  assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);
  assert_busy_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);
  assert_commit_at_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det));
  assert_no_prot_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !prot);
  assert_wait_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> !sda_oe);
endmodule

// File: tb/twowire_mem_slave_bench.sv
module twowire_mem_slave_bench;
  localparam int WRC = 400;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, msda = 1'b1;
  wire sda_oe, busy;
  wire sda_line = msda & ~sda_oe;
  int total = 0, bad = 0, pulses = 0, blen = 0;
  bit done = 1'b0, prev_oe = 1'b0;
  int model [16];

  twowire_mem_slave u_twowire_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .busy(busy));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && scl && sda_oe != prev_oe) chk(1'b0, "R11 oe moved with SCL high", sda_oe, prev_oe);
    prev_oe = sda_oe;
    if (busy) blen++;
    else if (blen != 0) begin
      pulses++;
      chk(blen == WRC, "R7 busy length", blen, WRC);
      blen = 0;
    end
  end

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic bstart();
    scl = 0; w(4); msda = 1; w(4); scl = 1; w(8); msda = 0; w(8); scl = 0; w(4);
  endtask
  task automatic bstop();
    scl = 0; w(4); msda = 0; w(4); scl = 1; w(8); msda = 1; w(8);
  endtask
  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      scl = 0; w(4); msda = b[i]; w(4); scl = 1; w(8);
    end
    scl = 0; w(4); msda = 1; w(4); scl = 1; w(4); ack = ~sda_line; w(4); scl = 0;
  endtask
  task automatic recv(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      scl = 0; w(8); scl = 1; w(4); b[i] = sda_line; w(4);
    end
    scl = 0; w(4); msda = give_ack ? 1'b0 : 1'b1; w(4); scl = 1; w(8); scl = 0; w(4); msda = 1;
  endtask
  task automatic wait_idle();
    while (busy) w(1);
    w(4);
  endtask

  initial begin
    bit a;
    logic [7:0] d;
    int p0;
    for (int i = 0; i < 16; i++) model[i] = 0;
    w(3);
    chk(sda_oe == 0 && busy == 0, "R1 reset outputs", {sda_oe, busy}, 0);
    rst_n = 1; w(10);
    chk(sda_oe == 0 && busy == 0, "R1 after reset", {sda_oe, busy}, 0);

    bstart(); send(8'hA2, a); chk(a, "R3 address ack", a, 1);
    send(8'h05, a); chk(a, "R5 word address ack", a, 1);
    send(8'h3C, a); chk(a, "R5 data ack", a, 1);
    bstop(); model[5] = 'h3C; w(6);
    chk(busy, "R7 busy after stop", busy, 1);
    bstart(); send(8'hA2, a); chk(!a, "R7 ignored while busy", a, 0); bstop();
    wait_idle();
    chk(pulses == 1, "R7 one busy pulse", pulses, 1);

    bstart(); send(8'hA2, a); send(8'h00, a); send(8'h81, a);
    chk(a, "R5 data ack addr 0", a, 1); bstop(); model[0] = 'h81; wait_idle();

    p0 = pulses;
    bstart(); send(8'hA2, a); send(8'h0F, a); chk(a, "R5 protected word address", a, 1);
    send(8'hC7, a); chk(!a, "R8 protected data nack", a, 0); bstop(); w(30);
    chk(pulses == p0 && !busy, "R8 no write cycle", pulses, p0);

    p0 = pulses;
    bstart(); send(8'hA2, a); send(8'h07, a); bstop(); w(30);
    chk(pulses == p0 && !busy, "R2 stop without data", pulses, p0);

    bstart(); send(8'hA6, a); chk(!a, "R4 select mismatch", a, 0);
    send(8'h05, a); chk(!a, "R4 later byte ignored", a, 0); bstop();
    bstart(); send(8'hB2, a); chk(!a, "R4 identifier mismatch", a, 0); bstop();

    bstart(); send(8'hA2, a); send(8'h05, a); bstart();
    send(8'hA3, a); chk(a, "R3 read address ack", a, 1);
    recv(1'b0, d); chk(d == model[5], "R6 readback", d, model[5]); bstop();

    bstart(); send(8'hA2, a); send(8'h07, a); bstart(); send(8'hA3, a);
    recv(1'b0, d); chk(d == model[7], "R2 addr 7 unchanged", d, model[7]); bstop();

    bstart(); send(8'hA2, a); send(8'h0E, a); bstart(); send(8'hA3, a);
    recv(1'b1, d); chk(d == model[14], "R9 read 14", d, model[14]);
    recv(1'b1, d); chk(d == model[15], "R8 addr 15 unchanged", d, model[15]);
    recv(1'b0, d); chk(d == model[0], "R9 wrap to 0", d, model[0]);
    recv(1'b0, d); chk(d == 8'hFF, "R10 silent after nack", d, 8'hFF);
    bstop(); w(10);
    chk(sda_oe == 0, "R10 released", sda_oe, 0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule